// File: doc/BRIEF.md
# Three-Phase Center-Aligned Dead-Time PWM Generator

This block drives the six gate signals of a three-phase inverter bridge: one upper and one lower switch per phase leg. Each phase is modulated with a center-aligned pulse whose width the host sets as a per-phase high time in timer ticks. The lower switch is the complement of the upper one, widened on both sides by a programmable dead-time, so the two switches of a leg are never on together. High times, the period and a reload divisor are sampled from the host inputs only at reload points, which fall once every `divisor` periods. The host requests a reload by raising a load-ready flag, and the block clears that flag and pulses an acknowledge when it has taken the values.

An initialise command captures the period, divisor, dead-time and minimum pulse width, and holds all gates off for a startup interval so that the bootstrap supplies can charge. Each phase then runs at half of the period until the first reload is accepted. A high time whose narrowest resulting pulse would be shorter than the minimum width is pinned to fully off or fully on. A falling edge on the active-low fault input, or a stop command, turns every gate off at once. The block stays off until the next initialise command. The registered level of the fault pin can be read back.

Top module: `tri_phase_pwm`

## Requirements
- R1: With period T, dead-time D and an accepted high time H in normal range, the upper gate of a phase is high for exactly 2*floor((H-D)/2) consecutive ticks per period, centered on tick floor(T/2) of the period; the three phases use their own high times (gateHi bit 0 is phase A, bit 1 is B, bit 2 is C).
- R2: The lower gate of a phase is low for exactly 2*floor((H+D)/2) ticks around the same center and high otherwise; with even H and D its falling edge leads the upper gate's rising edge by exactly D ticks.
- R3: After an initialise command given while idle, all six gates stay low for HOLD_CYCLES ticks; the lower gates go high exactly HOLD_CYCLES+1 clock edges after the edge that samples the command.
- R4: Until the first reload is accepted after initialise, every phase uses a high time of floor(T/2) with the period captured at initialise.
- R5: Host high times, period and divisor are taken only at the end of the last period of a divisor window and only while ldOk is 1; with ldOk low, changed host values have no effect on the gates, and with the flag re-armed right away the acknowledges are exactly divisor*T ticks apart.
- R6: When values are taken, ldOk returns to 0 and loadIrq is high for exactly one clock, on the same edge; ldSet sets ldOk.
- R7: A high time below D+MPW holds the upper gate low and the lower gate high for whole periods; a high time equal to D+MPW still gives an upper pulse of floor(MPW/2)*2 ticks.
- R8: A high time H with H+D+MPW > T (and H not below D+MPW) holds the upper gate high and the lower gate low for whole periods.
- R9: A falling edge of faultN drives all six gates low from the next clock edge on; they stay low, whatever faultN does, until a new initialise command restarts the startup sequence.
- R10: faultLevel shows the faultN level sampled at the previous clock edge: 1 for high, 0 for low.
- R11: A stop command drives all six gates low from the next edge and keeps them low until an initialise command.
- R12: The upper and lower gate of the same phase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, one tick per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| initCmd | input | 1 | Initialise: capture settings and start the startup hold |
| stopCmd | input | 1 | Halt: all gates off until the next initialise |
| faultN | input | 1 | Active-low fault pin; a falling edge shuts the bridge off |
| periodIn | input | 16 | Period T in ticks |
| prescIn | input | 16 | Reload divisor: periods per reload window |
| htA | input | 16 | Phase A high time in ticks |
| htB | input | 16 | Phase B high time in ticks |
| htC | input | 16 | Phase C high time in ticks |
| deadIn | input | 16 | Dead-time in ticks, captured at initialise |
| mpwIn | input | 16 | Minimum pulse width in ticks, captured at initialise |
| ldSet | input | 1 | One-cycle request that sets the load-ready flag |
| gateHi | output | 3 | Upper switch gates, bit 0 phase A to bit 2 phase C |
| gateLo | output | 3 | Lower switch gates, bit 0 phase A to bit 2 phase C |
| ldOk | output | 1 | Load-ready flag: 1 while host values wait to be taken |
| loadIrq | output | 1 | One-cycle pulse when host values are taken |
| faultLevel | output | 1 | Registered level of the fault pin |

## Verification
Every cycle, the assertions check that no leg has both gates on, that a fault edge or a stop command leaves all gates off on the following edge, and that an acknowledge only follows an armed load flag and always leaves it cleared. Pulse widths, the dead-time gap, the startup count, the half-period default, the spacing of reloads set by the divisor, the ignoring of unarmed host values and the two clamping regions depend on configured values. Only the bench scenarios can show them, by measuring edges against numbers worked out from the requirements. The same holds for the latched fault shutdown and its release by a new initialise.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } pwmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic initLoad;  // capture settings, default half-period high times
    logic startRun;  // clear period and window counters
    logic active;    // counting, gates follow the compare
    logic reload;    // take host values at this period end
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_phase.sv
module pwm_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] ht,
  input  logic [CW-1:0] dead,
  input  logic [CW-1:0] mpw,
  output logic          hiOut,
  output logic          loOut
);

  localparam int EW = CW + 2;

  logic [EW-1:0] eCnt, eT, eHt, eDt, eMpw;
  logic [EW-1:0] floorW, center, hwTop, hwBot;
  logic          offMode, fullMode, topOn, botOff;

  always_comb begin
    eCnt   = EW'(cnt);
    eT     = EW'(period);
    eHt    = EW'(ht);
    eDt    = EW'(dead);
    eMpw   = EW'(mpw);
    floorW = eDt + eMpw;
    center = eT >> 1;
    hwTop  = (eHt - eDt) >> 1;
    hwBot  = (eHt + eDt) >> 1;
    offMode  = eHt < floorW;
    fullMode = !offMode && ((eHt + floorW) > eT);
    topOn  = (eCnt >= (center - hwTop)) && (eCnt < (center + hwTop));
    botOff = (eCnt >= (center - hwBot)) && (eCnt < (center + hwBot));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiOut <= 1'b0;
      loOut <= 1'b0;
    end else if (!active) begin
      hiOut <= 1'b0;
      loOut <= 1'b0;
    end else if (offMode) begin
      hiOut <= 1'b0;
      loOut <= 1'b1;
    end else if (fullMode) begin
      hiOut <= 1'b1;
      loOut <= 1'b0;
    end else begin
      hiOut <= topOn;
      loOut <= !botOff;
    end
  end

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CW     = 16,
  parameter int PHASES = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pwmStrobe_t               strb,
  input  logic [CW-1:0]            periodIn,
  input  logic [CW-1:0]            prescIn,
  input  logic [PHASES-1:0][CW-1:0] htIn,
  input  logic [CW-1:0]            deadIn,
  input  logic [CW-1:0]            mpwIn,
  output logic                     reloadPoint,
  output logic [PHASES-1:0]        gateHi,
  output logic [PHASES-1:0]        gateLo
);

  logic [CW-1:0] period, presc, dead, mpw, cnt, pcnt;
  logic [PHASES-1:0][CW-1:0] ht;
  logic lastTick, lastPeriod;

  always_comb begin
    lastTick    = ({1'b0, cnt} + 1'b1) >= {1'b0, period};
    lastPeriod  = ({1'b0, pcnt} + 1'b1) >= {1'b0, presc};
    reloadPoint = strb.active && lastTick && lastPeriod;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period <= '0;
      presc  <= '0;
      dead   <= '0;
      mpw    <= '0;
      cnt    <= '0;
      pcnt   <= '0;
      ht     <= '0;
    end else if (strb.initLoad) begin
      period <= periodIn;
      presc  <= prescIn;
      dead   <= deadIn;
      mpw    <= mpwIn;
      for (int i = 0; i < PHASES; i++) ht[i] <= periodIn >> 1;
    end else if (strb.startRun) begin
      cnt  <= '0;
      pcnt <= '0;
    end else if (strb.active) begin
      if (lastTick) begin
        cnt <= '0;
        if (reloadPoint) begin
          pcnt <= '0;
          if (strb.reload) begin
            period <= periodIn;
            presc  <= prescIn;
            ht     <= htIn;
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < PHASES; g++) begin : gPhase
    pwm_phase #(.CW(CW)) uPhase (
      .clk    (clk),
      .rstN   (rstN),
      .active (strb.active),
      .cnt    (cnt),
      .period (period),
      .ht     (ht[g]),
      .dead   (dead),
      .mpw    (mpw),
      .hiOut  (gateHi[g]),
      .loOut  (gateLo[g])
    );
  end

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int HOLD_CYCLES = 32000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initCmd,
  input  logic       stopCmd,
  input  logic       faultN,
  input  logic       ldSet,
  input  logic       reloadPoint,
  output pwmStrobe_t strb,
  output logic       ldOk,
  output logic       loadIrq,
  output logic       faultLevel
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  pwmState_e state;
  logic [HW-1:0] holdCnt;
  logic faultPrev, faultFall, kill, holdDone;

  always_comb begin
    faultFall = faultPrev && !faultN;
    kill      = faultFall || stopCmd;
    holdDone  = (state == ST_HOLD) && (holdCnt == HOLD_LAST);
    strb.initLoad = initCmd && !kill;
    strb.startRun = holdDone && !kill && !initCmd;
    strb.active   = (state == ST_RUN) && !kill && !initCmd;
    strb.reload   = reloadPoint && ldOk && strb.active;
  end

  assign faultLevel = faultPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      holdCnt   <= '0;
      faultPrev <= 1'b1;
      ldOk      <= 1'b0;
      loadIrq   <= 1'b0;
    end else begin
      faultPrev <= faultN;
      loadIrq   <= strb.reload;
      if (strb.initLoad) ldOk <= 1'b0;
      else if (strb.reload) ldOk <= 1'b0;
      else if (ldSet) ldOk <= 1'b1;
      if (kill) begin
        state <= ST_IDLE;
      end else if (initCmd) begin
        state   <= ST_HOLD;
        holdCnt <= '0;
      end else if (holdDone) begin
        state <= ST_RUN;
      end else if (state == ST_HOLD) begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
  import pwm_pkg::*;
#(
  parameter int CW          = 16,
  parameter int HOLD_CYCLES = 32000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          initCmd,
  input  logic          stopCmd,
  input  logic          faultN,
  input  logic [CW-1:0] periodIn,
  input  logic [CW-1:0] prescIn,
  input  logic [CW-1:0] htA,
  input  logic [CW-1:0] htB,
  input  logic [CW-1:0] htC,
  input  logic [CW-1:0] deadIn,
  input  logic [CW-1:0] mpwIn,
  input  logic          ldSet,
  output logic [2:0]    gateHi,
  output logic [2:0]    gateLo,
  output logic          ldOk,
  output logic          loadIrq,
  output logic          faultLevel
);

  pwmStrobe_t strb;
  logic reloadPoint;
  logic [2:0][CW-1:0] htBus;

  assign htBus = {htC, htB, htA};

  pwm_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .initCmd     (initCmd),
    .stopCmd     (stopCmd),
    .faultN      (faultN),
    .ldSet       (ldSet),
    .reloadPoint (reloadPoint),
    .strb        (strb),
    .ldOk        (ldOk),
    .loadIrq     (loadIrq),
    .faultLevel  (faultLevel)
  );

  pwm_datapath #(.CW(CW), .PHASES(3)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .periodIn    (periodIn),
    .prescIn     (prescIn),
    .htIn        (htBus),
    .deadIn      (deadIn),
    .mpwIn       (mpwIn),
    .reloadPoint (reloadPoint),
    .gateHi      (gateHi),
    .gateLo      (gateLo)
  );

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       faultN,
  input logic       stopCmd,
  input logic [2:0] gateHi,
  input logic [2:0] gateLo,
  input logic       ldOk,
  input logic       loadIrq
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi & gateLo) == 3'b000); // R12

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |=> (gateHi == 3'b000) && (gateLo == 3'b000)); // R9

  AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (gateHi == 3'b000) && (gateLo == 3'b000)); // R11

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    loadIrq |-> !ldOk); // R6

  AST_ACK_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    loadIrq |-> $past(ldOk)); // R5

endmodule

bind tri_phase_pwm pwm_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .faultN  (faultN),
  .stopCmd (stopCmd),
  .gateHi  (gateHi),
  .gateLo  (gateLo),
  .ldOk    (ldOk),
  .loadIrq (loadIrq)
);

// File: tb/sim_tri_phase_pwm.sv
`timescale 1ns/1ps
module sim_tri_phase_pwm;

  localparam int HOLD = 40;
  localparam int TP   = 200;
  localparam int DT   = 10;
  localparam int MPW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initCmd = 1'b0, stopCmd = 1'b0, faultN = 1'b1, ldSet = 1'b0;
  logic [15:0] periodIn = 16'(TP), prescIn = 16'd1;
  logic [15:0] htA = 16'd60, htB = 16'd100, htC = 16'd140;
  logic [15:0] deadIn = 16'(DT), mpwIn = 16'(MPW);
  logic [2:0] gateHi, gateLo;
  logic ldOk, loadIrq, faultLevel;

  int checks = 0;
  int fails = 0;
  bit overlapSeen = 0;

  typedef struct { string tag; int expv; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  tri_phase_pwm #(.CW(16), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .initCmd(initCmd), .stopCmd(stopCmd),
    .faultN(faultN), .periodIn(periodIn), .prescIn(prescIn),
    .htA(htA), .htB(htB), .htC(htC), .deadIn(deadIn), .mpwIn(mpwIn),
    .ldSet(ldSet), .gateHi(gateHi), .gateLo(gateLo), .ldOk(ldOk),
    .loadIrq(loadIrq), .faultLevel(faultLevel)
  );

  always @(negedge clk) if (rstN && ((gateHi & gateLo) != 3'b000)) overlapSeen = 1;

  // driver side: push expectation
  task automatic expectItem(input string tag, input int v);
    item_t it;
    it.tag = tag;
    it.expv = v;
    sbq.push_back(it);
  endtask

  // monitor side: pop and compare against observed value
  task automatic observe(input int actual);
    item_t it;
    it = sbq.pop_front();
    checks++;
    if (actual != it.expv) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", it.tag, actual, it.expv);
    end
  endtask

  task automatic cmp(input string tag, input int actual, input int expv);
    expectItem(tag, expv);
    observe(actual);
  endtask

  task automatic pulse(input int which);
    if (which == 0) initCmd = 1'b1;
    else if (which == 1) stopCmd = 1'b1;
    else ldSet = 1'b1;
    @(negedge clk);
    initCmd = 1'b0;
    stopCmd = 1'b0;
    ldSet = 1'b0;
  endtask

  function automatic logic pick(input int idx, input bit hi);
    return hi ? gateHi[idx] : gateLo[idx];
  endfunction

  // width of the next run where the chosen gate equals lvl
  task automatic runWidth(input int idx, input bit hi, input bit lvl, output int w);
    int guard = 0;
    w = -1;
    while (pick(idx, hi) == lvl && guard < 3000) begin @(negedge clk); guard++; end
    while (pick(idx, hi) != lvl && guard < 3000) begin @(negedge clk); guard++; end
    if (guard >= 3000) return;
    w = 0;
    while (pick(idx, hi) == lvl && guard < 6000) begin @(negedge clk); w++; guard++; end
  endtask

  task automatic startupCount(output int n);
    n = 0;
    while (!gateLo[0] && n < HOLD + 500) begin @(negedge clk); n++; end
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!loadIrq && n < 3000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int w, n;
    bit bad;
    repeat (3) @(negedge clk);
    cmp("reset gates R11", {29'd0, gateHi} | {29'd0, gateLo}, 0);
    cmp("reset flag R6", int'(ldOk) + int'(loadIrq), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // startup hold and default duty
    pulse(0);
    startupCount(n);
    cmp("startup edge count R3", n, HOLD + 1);
    runWidth(0, 1'b1, 1'b1, w);
    cmp("default half-period top width R4", w, 2 * ((TP / 2 - DT) / 2));
    runWidth(0, 1'b0, 1'b0, w);
    cmp("bottom low width R2", w, 2 * ((TP / 2 + DT) / 2));
    // dead gap: bottom falls, then top rises
    while (!gateLo[0]) @(negedge clk);
    while (gateLo[0]) @(negedge clk);
    n = 0;
    while (!gateHi[0] && n < 1000) begin @(negedge clk); n++; end
    cmp("dead gap R2", n, DT);

    // host value changed without flag: ignored
    repeat (3 * TP) @(negedge clk);
    runWidth(0, 1'b1, 1'b1, w);
    cmp("unarmed values ignored R5", w, 2 * ((TP / 2 - DT) / 2));

    // armed reload
    pulse(2);
    cmp("flag set R6", int'(ldOk), 1);
    waitIrq(n);
    cmp("ack clears flag R6", int'(ldOk), 0);
    @(negedge clk);
    cmp("ack single cycle R6", int'(loadIrq), 0);
    runWidth(0, 1'b1, 1'b1, w);
    cmp("phase A width R1", w, 2 * ((60 - DT) / 2));
    runWidth(1, 1'b1, 1'b1, w);
    cmp("phase B width R1", w, 2 * ((100 - DT) / 2));
    runWidth(2, 1'b1, 1'b1, w);
    cmp("phase C width R1", w, 2 * ((140 - DT) / 2));

    // divisor spacing
    prescIn = 16'd3;
    pulse(2);
    waitIrq(n);
    ldSet = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; ldSet = 1'b0; end while (!loadIrq && n < 3000);
    cmp("reload spacing divisor*T R5", n, 3 * TP);

    // clamping
    htA = 16'(DT + MPW - 2);
    htB = 16'(DT + MPW);
    htC = 16'(TP - 10);
    pulse(2);
    waitIrq(n);
    bad = 0;
    for (int i = 0; i < 2 * TP; i++) begin
      @(negedge clk);
      if (gateHi[0] || !gateLo[0]) bad = 1;
    end
    cmp("low clamp holds off R7", int'(bad), 0);
    runWidth(1, 1'b1, 1'b1, w);
    cmp("boundary pulse equals MPW R7", w, 2 * (MPW / 2));
    bad = 0;
    for (int i = 0; i < 2 * TP; i++) begin
      @(negedge clk);
      if (!gateHi[2] || gateLo[2]) bad = 1;
    end
    cmp("high clamp holds on R8", int'(bad), 0);

    // stop
    pulse(1);
    cmp("stop gates off R11", {29'd0, gateHi} | {29'd0, gateLo}, 0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if ((gateHi | gateLo) != 3'b000) bad = 1;
    end
    cmp("stop stays off R11", int'(bad), 0);

    // fault latch
    pulse(0);
    repeat (HOLD + 300) @(negedge clk);
    faultN = 1'b0;
    @(negedge clk);
    cmp("fault gates off R9", {29'd0, gateHi} | {29'd0, gateLo}, 0);
    cmp("fault level low R10", int'(faultLevel), 0);
    faultN = 1'b1;
    repeat (2) @(negedge clk);
    cmp("fault level high R10", int'(faultLevel), 1);
    bad = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if ((gateHi | gateLo) != 3'b000) bad = 1;
    end
    cmp("fault latched off R9", int'(bad), 0);
    pulse(0);
    startupCount(n);
    cmp("restart after fault R9", n, HOLD + 1);

    cmp("no leg overlap R12", int'(overlapSeen), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule